// File: doc/BRIEF.md
# Byte-Wide Big-Endian Data Store

This block is the data store used in the memory stage of a small in-order pipeline. Its storage is a set of byte-wide locations. A 32-bit load or store always covers a group of four neighbouring bytes. The most significant byte of the word sits at the lowest address of the group.

Each cycle the block takes a byte address, a word of write data and the two access enables. A store is committed on the rising clock edge. A load is assembled combinationally from the current address, and it reads as zero when the read enable is low. The ALU result, the destination register index and the two write-back controls are not used here. They are captured, together with the load value, in the register that feeds write-back. An instruction with neither enable set therefore reaches write-back unchanged.

Top module: `byte_word_store`

## Requirements
- R1: While reset is asserted, every byte location becomes zero and every write-back output becomes zero.
- R2: When the write enable is high at a rising edge, the four bytes of the addressed word are replaced. A later load from the same address returns the stored word.
- R3: When the write enable is high, the byte at the group's lowest address receives bits 31:24 of the write data, and the byte at its highest address receives bits 7:0.
- R4: Address bits 1:0 are ignored, so every access goes to the four-byte group that starts at the address with those bits cleared.
- R5: Address bits above bit 4 are ignored, so addresses that differ only in those bits reach the same location.
- R6: The load output is all zeros whenever the read enable is low.
- R7: When the write enable is low at an edge, no stored byte changes.
- R8: A load reflects the stored contents combinationally. When a load and a store hit the same word in the same cycle, the load shows the old word, and the new word becomes visible after the edge.
- R9: At every rising edge outside reset, the write-back register captures the ALU result, the destination index, the memory-to-register select, the register-write enable and the current load value.
- R10: The 32 bytes hold eight independent words. A store to one word leaves the other seven unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Byte address of the access |
| wdata_i | input | 32 | Word to store |
| rd_en_i | input | 1 | Load enable |
| wr_en_i | input | 1 | Store enable |
| alu_res_i | input | 32 | ALU result passed toward write-back |
| dst_idx_i | input | 5 | Destination register index |
| sel_mem_i | input | 1 | Write-back source select (memory vs ALU) |
| reg_we_i | input | 1 | Register-file write enable |
| load_o | output | 32 | Combinational load value |
| wb_mem_o | output | 32 | Registered load value |
| wb_alu_o | output | 32 | Registered ALU result |
| wb_dst_o | output | 5 | Registered destination index |
| wb_sel_mem_o | output | 1 | Registered write-back source select |
| wb_reg_we_o | output | 1 | Registered register-file write enable |

## Verification
The byte array itself is not visible at the ports, so a wrong internal state only appears when a later load reads the affected word. These errors include a lost or stray write, a wrong lane order, or a wrong alias. Each one shows on `load_o` as soon as that word is read back, and on `wb_mem_o` one edge later. The order in which a word's bytes are placed cannot be seen through aligned word loads alone, so a bound checker compares the byte array against the stored data one edge after each store.

// File: rtl/bws_pkg.sv
package bws_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int LANES  = WORD_W / BYTE_W;
  localparam int LANE_W = $clog2(LANES);

  // big-endian: lane 0 (lowest address) carries the top byte
  function automatic logic [BYTE_W-1:0] lane_byte(input logic [WORD_W-1:0] w, input int lane);
    return w[WORD_W-1-lane*BYTE_W -: BYTE_W];
  endfunction
endpackage

// File: rtl/bws_addr_map.sv
module bws_addr_map #(
  parameter int ADDR_W = 5
) (
  input  logic [31:0]       addr_i,
  output logic [ADDR_W-1:0] base_o
);
  import bws_pkg::*;
  logic unused_addr_bits;
  assign unused_addr_bits = ^{addr_i[31:ADDR_W], addr_i[LANE_W-1:0]};
  assign base_o = {addr_i[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
endmodule

// File: rtl/bws_bank.sv
module bws_bank #(
  parameter int ADDR_W = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                base_i,
  input  logic [bws_pkg::WORD_W-1:0]       wdata_i,
  output logic [bws_pkg::WORD_W-1:0]       rword_o,
  output logic [(1<<ADDR_W)*bws_pkg::BYTE_W-1:0] flat_o
);
  import bws_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int GRP_W = ADDR_W - LANE_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [GRP_W-1:0]  grp;
  assign grp = base_i[ADDR_W-1:LANE_W];

  logic unused_base_low;
  assign unused_base_low = ^base_i[LANE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      for (int l = 0; l < LANES; l++) mem[{grp, LANE_W'(l)}] <= lane_byte(wdata_i, l);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rword_o[WORD_W-1-g*BYTE_W -: BYTE_W] = mem[{grp, LANE_W'(g)}];
  end

  for (genvar d = 0; d < DEPTH; d++) begin : g_flat
    assign flat_o[d*BYTE_W +: BYTE_W] = mem[d];
  end
endmodule

// File: rtl/bws_wb_reg.sv
module bws_wb_reg #(
  parameter int REG_IDX_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [bws_pkg::WORD_W-1:0] mem_i,
  input  logic [bws_pkg::WORD_W-1:0] alu_i,
  input  logic [REG_IDX_W-1:0]       dst_i,
  input  logic                       sel_mem_i,
  input  logic                       reg_we_i,
  output logic [bws_pkg::WORD_W-1:0] mem_o,
  output logic [bws_pkg::WORD_W-1:0] alu_o,
  output logic [REG_IDX_W-1:0]       dst_o,
  output logic                       sel_mem_o,
  output logic                       reg_we_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_o <= '0; alu_o <= '0; dst_o <= '0; sel_mem_o <= 1'b0; reg_we_o <= 1'b0;
    end else begin
      mem_o <= mem_i; alu_o <= alu_i; dst_o <= dst_i; sel_mem_o <= sel_mem_i; reg_we_o <= reg_we_i;
    end
  end
endmodule

// File: rtl/byte_word_store.sv
module byte_word_store #(
  parameter int ADDR_W    = 5,
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          addr_i,
  input  logic [31:0]          wdata_i,
  input  logic                 rd_en_i,
  input  logic                 wr_en_i,
  input  logic [31:0]          alu_res_i,
  input  logic [REG_IDX_W-1:0] dst_idx_i,
  input  logic                 sel_mem_i,
  input  logic                 reg_we_i,
  output logic [31:0]          load_o,
  output logic [31:0]          wb_mem_o,
  output logic [31:0]          wb_alu_o,
  output logic [REG_IDX_W-1:0] wb_dst_o,
  output logic                 wb_sel_mem_o,
  output logic                 wb_reg_we_o
);
  import bws_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  // named internal events for the checker
  logic [ADDR_W-1:0]        acc_base;
  logic                     wr_fire;
  logic [WORD_W-1:0]        raw_word;
  logic [DEPTH*BYTE_W-1:0]  store_flat;

  assign wr_fire = wr_en_i;

  bws_addr_map #(.ADDR_W(ADDR_W)) u_map (.addr_i(addr_i), .base_o(acc_base));

  bws_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we_i(wr_fire), .base_i(acc_base),
    .wdata_i(wdata_i), .rword_o(raw_word), .flat_o(store_flat)
  );

  assign load_o = rd_en_i ? raw_word : '0;

  bws_wb_reg #(.REG_IDX_W(REG_IDX_W)) u_wb (
    .clk(clk), .rst_n(rst_n), .mem_i(load_o), .alu_i(alu_res_i), .dst_i(dst_idx_i),
    .sel_mem_i(sel_mem_i), .reg_we_i(reg_we_i), .mem_o(wb_mem_o), .alu_o(wb_alu_o),
    .dst_o(wb_dst_o), .sel_mem_o(wb_sel_mem_o), .reg_we_o(wb_reg_we_o)
  );
endmodule

// File: rtl/byte_word_store_chk.sv
module byte_word_store_chk #(
  parameter int ADDR_W    = 5,
  parameter int REG_IDX_W = 5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        rd_en_i,
  input logic                        wr_fire,
  input logic [ADDR_W-1:0]           acc_base,
  input logic [31:0]                 wdata_i,
  input logic [31:0]                 alu_res_i,
  input logic [REG_IDX_W-1:0]        dst_idx_i,
  input logic [31:0]                 load_o,
  input logic [31:0]                 wb_mem_o,
  input logic [31:0]                 wb_alu_o,
  input logic [REG_IDX_W-1:0]        wb_dst_o,
  input logic [(1<<ADDR_W)*8-1:0]    store_flat
);
  logic [ADDR_W-1:0] last_base;
  logic [31:0]       last_data;
  logic [31:0]       placed;

  always_ff @(posedge clk) begin
    last_base <= acc_base;
    last_data <= wdata_i;
  end

  // gather the group written last edge, lowest address into the top byte
  always_comb begin
    for (int l = 0; l < 4; l++) begin
      placed[31-l*8 -: 8] = store_flat[({last_base[ADDR_W-1:2], 2'(l)})*8 +: 8];
    end
  end

  p_msb_low_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> placed == last_data);

  p_hold_without_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(store_flat));

  p_idle_load_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |-> load_o == 32'h0);

  p_alu_forward_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wb_alu_o == $past(alu_res_i)) && (wb_dst_o == $past(dst_idx_i)));

  p_load_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> wb_mem_o == $past(load_o));
endmodule

bind byte_word_store byte_word_store_chk #(.ADDR_W(ADDR_W), .REG_IDX_W(REG_IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .wr_fire(wr_fire), .acc_base(acc_base),
  .wdata_i(wdata_i), .alu_res_i(alu_res_i), .dst_idx_i(dst_idx_i), .load_o(load_o),
  .wb_mem_o(wb_mem_o), .wb_alu_o(wb_alu_o), .wb_dst_o(wb_dst_o), .store_flat(store_flat)
);

// File: tb/byte_word_store_bench.sv
module byte_word_store_bench;
  localparam int CLK_T = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] addr = '0, wdata = '0, alu = '0;
  logic rd = 1'b0, wr = 1'b0, selm = 1'b0, rwe = 1'b0;
  logic [4:0] dst = '0;
  logic [31:0] load_o, wb_mem, wb_alu;
  logic [4:0] wb_dst;
  logic wb_sel, wb_we;

  int checks = 0, errors = 0;
  logic [7:0] shadow [32];

  always #(CLK_T/2) clk = ~clk;

  byte_word_store u_byte_word_store (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .rd_en_i(rd), .wr_en_i(wr),
    .alu_res_i(alu), .dst_idx_i(dst), .sel_mem_i(selm), .reg_we_i(rwe), .load_o(load_o),
    .wb_mem_o(wb_mem), .wb_alu_o(wb_alu), .wb_dst_o(wb_dst), .wb_sel_mem_o(wb_sel), .wb_reg_we_o(wb_we)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model: group index from bits 4:2, big-endian assembly
  function automatic logic [31:0] model_word(input logic [31:0] a);
    int b;
    b = int'(a[4:2]) * 4;
    return {shadow[b], shadow[b+1], shadow[b+2], shadow[b+3]};
  endfunction

  task automatic model_store(input logic [31:0] a, input logic [31:0] d);
    int b;
    b = int'(a[4:2]) * 4;
    shadow[b] = d[31:24]; shadow[b+1] = d[23:16]; shadow[b+2] = d[15:8]; shadow[b+3] = d[7:0];
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1; rd = 1'b0;
    @(negedge clk); wr = 1'b0;
    model_store(a, d);
  endtask

  task automatic load_check(input string req, input logic [31:0] a);
    @(negedge clk); addr = a; rd = 1'b1; #1;
    check(req, load_o, model_word(a));
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) load_check("R1", 32'(i*4));
    check("R1 wb_alu", wb_alu, 32'h0);
    check("R1 wb_ctl", {25'd0, wb_dst, wb_sel, wb_we}, 32'h0);
  endtask

  task automatic t_roundtrip;
    store(32'h0000_0004, 32'hA1B2_C3D4);
    load_check("R2", 32'h0000_0004);
    store(32'h0000_0004, 32'h1122_3344);
    load_check("R2 overwrite", 32'h0000_0004);
  endtask

  task automatic t_align;
    store(32'h0000_000B, 32'hCAFE_F00D);
    load_check("R4 read base", 32'h0000_0008);
    load_check("R4 read off1", 32'h0000_0009);
    load_check("R4 read off3", 32'h0000_000B);
    check("R4 value", load_o, 32'hCAFE_F00D);
  endtask

  task automatic t_alias;
    store(32'hFFFF_FFF0, 32'h5566_7788);
    load_check("R5 low alias", 32'h0000_0010);
    check("R5 value", load_o, 32'h5566_7788);
    load_check("R5 high alias", 32'h1234_5670);
  endtask

  task automatic t_idle_zero;
    @(negedge clk); addr = 32'h4; rd = 1'b0; #1;
    check("R6 load low", load_o, 32'h0);
    @(negedge clk); #1;
    check("R6 wb_mem", wb_mem, 32'h0);
  endtask

  task automatic t_no_write;
    @(negedge clk); addr = 32'h4; wdata = 32'hDEAD_BEEF; wr = 1'b0; rd = 1'b0;
    @(negedge clk);
    load_check("R7", 32'h4);
  endtask

  task automatic t_same_cycle;
    logic [31:0] old;
    old = model_word(32'h14);
    @(negedge clk); addr = 32'h14; wdata = 32'h0BAD_CAFE; wr = 1'b1; rd = 1'b1; #1;
    check("R8 old visible", load_o, old);
    @(negedge clk); wr = 1'b0; #1;
    model_store(32'h14, 32'h0BAD_CAFE);
    check("R8 new visible", load_o, 32'h0BAD_CAFE);
    check("R8 wb old", wb_mem, old);
  endtask

  task automatic t_passthrough;
    @(negedge clk); rd = 1'b0; wr = 1'b0; alu = 32'h8765_4321; dst = 5'd19; selm = 1'b0; rwe = 1'b1;
    @(negedge clk); #1;
    check("R9 alu", wb_alu, 32'h8765_4321);
    check("R9 ctl", {25'd0, wb_dst, wb_sel, wb_we}, {25'd0, 5'd19, 1'b0, 1'b1});
    check("R9 mem zero", wb_mem, 32'h0);
    alu = 32'h0; dst = 5'd7; selm = 1'b1; rwe = 1'b0; addr = 32'h8; rd = 1'b1;
    @(negedge clk); #1;
    check("R9 ctl2", {25'd0, wb_dst, wb_sel, wb_we}, {25'd0, 5'd7, 1'b1, 1'b0});
    check("R9 mem", wb_mem, model_word(32'h8));
  endtask

  task automatic t_fill_all;
    for (int i = 0; i < 8; i++) store(32'(i*4), 32'h1000_0001 * (i + 3));
    for (int i = 0; i < 8; i++) load_check("R10", 32'(i*4));
  endtask

  initial begin
    for (int i = 0; i < 32; i++) shadow[i] = 8'h0;
    repeat (3) @(negedge clk);
    #1; check("R1 wb_mem in reset", wb_mem, 32'h0);
    rst_n = 1'b1;
    t_reset();
    t_roundtrip();
    t_align();
    t_alias();
    t_idle_zero();
    t_no_write();
    t_same_cycle();
    t_passthrough();
    t_fill_all();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_T * 20000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule